// File: doc/BRIEF.md
# Replay and Overwrite Pointer Control for a Two-Way FIFO Pair

This block holds the pointers for a pair of FIFOs that carry data in opposite directions: a wide-to-narrow queue (A-to-B) and a narrow-to-wide queue (B-to-A). It drives the memory addresses for both queues and reports how many entries each one holds. The memory arrays and the flag logic sit outside the block.

Two pointers have a saved copy. The read pointer of the A-to-B queue can be marked and later restored. The consumer can then read a block of entries again, and the occupancy of that queue rises by the number of entries replayed. The write pointer of the B-to-A queue can also be marked and restored. The producer can then write a block again over the same slots, and the occupancy of that queue falls by the number of entries discarded. The mark controls are active high and come from a command register outside the block. The restore inputs are active low.

Top module: `ptr_mark_ctrl`

## Requirements
- R1: While `rst_n` is low, all four live pointers and both saved pointers are zero. After reset, every address output and both counts read 0.
- R2: Each pointer is AW+1 bits wide. An address output is the low AW bits of its pointer. An accepted push or pop advances its pointer by one, modulo 2^(AW+1). A count is the write pointer minus the read pointer, modulo 2^(AW+1), so a full queue reads 2^AW and an empty one reads 0.
- R3: A push to a queue whose count is 2^AW is ignored. A pop from a queue whose count is 0 is ignored. In both cases the count and the addresses do not change.
- R4: When `a2b_mark` is high at a clock edge, the saved read pointer takes the value the A-to-B read pointer had before that edge. A pop in the same cycle does not change the saved value.
- R5: When `a2b_replay_n` is low at a clock edge, the A-to-B read pointer is loaded from its saved copy. The A-to-B count becomes the write pointer minus the saved pointer.
- R6: A replay takes priority over an A-to-B pop in the same cycle. The pop is dropped.
- R7: When `b2a_mark` is high at a clock edge, the saved write pointer takes the value the B-to-A write pointer had before that edge.
- R8: When `b2a_redo_n` is low at a clock edge, the B-to-A write pointer is loaded from its saved copy, so the B-to-A count falls. A push in the same cycle is dropped.
- R9: When a mark and a restore of the same pointer happen in the same cycle, the pointer takes the previously saved value. The saved copy takes the pointer's value from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a2b_push | input | 1 | Write one entry into the A-to-B queue |
| a2b_pop | input | 1 | Read one entry from the A-to-B queue |
| a2b_mark | input | 1 | Save the A-to-B read pointer |
| a2b_replay_n | input | 1 | Restore the A-to-B read pointer, active low |
| b2a_push | input | 1 | Write one entry into the B-to-A queue |
| b2a_pop | input | 1 | Read one entry from the B-to-A queue |
| b2a_mark | input | 1 | Save the B-to-A write pointer |
| b2a_redo_n | input | 1 | Restore the B-to-A write pointer, active low |
| a2b_wr_addr | output | AW | A-to-B write address |
| a2b_rd_addr | output | AW | A-to-B read address |
| b2a_wr_addr | output | AW | B-to-A write address |
| b2a_rd_addr | output | AW | B-to-A read address |
| a2b_count | output | AW+1 | A-to-B occupancy |
| b2a_count | output | AW+1 | B-to-A occupancy |

## Verification
The bench builds the block with AW=3, which gives eight-entry queues. With that depth, random traffic fills and drains each queue often. The pointers pass the address wrap and the extra wrap bit many times within a few thousand cycles. Restores are issued only when the saved pointer still lies within one queue depth of the opposite pointer. Under that condition, both the rising replayed count and the falling overwrite count can be predicted exactly.

// File: rtl/ptr_mark_ctrl.sv
module ptr_mark_ctrl #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a2b_push,
  input  logic          a2b_pop,
  input  logic          a2b_mark,
  input  logic          a2b_replay_n,
  input  logic          b2a_push,
  input  logic          b2a_pop,
  input  logic          b2a_mark,
  input  logic          b2a_redo_n,
  output logic [AW-1:0] a2b_wr_addr,
  output logic [AW-1:0] a2b_rd_addr,
  output logic [AW-1:0] b2a_wr_addr,
  output logic [AW-1:0] b2a_rd_addr,
  output logic [AW:0]   a2b_count,
  output logic [AW:0]   b2a_count
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] a2b_wp, a2b_rp, a2b_mk;
  logic [PW-1:0] b2a_wp, b2a_rp, b2a_mk;

  assign a2b_count = a2b_wp - a2b_rp;
  assign b2a_count = b2a_wp - b2a_rp;

  wire a2b_push_ok = a2b_push && (a2b_count != DEPTH);
  wire a2b_pop_ok  = a2b_pop  && (a2b_count != '0);
  wire b2a_push_ok = b2a_push && (b2a_count != DEPTH);
  wire b2a_pop_ok  = b2a_pop  && (b2a_count != '0);

  assign a2b_wr_addr = a2b_wp[AW-1:0];
  assign a2b_rd_addr = a2b_rp[AW-1:0];
  assign b2a_wr_addr = b2a_wp[AW-1:0];
  assign b2a_rd_addr = b2a_rp[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a2b_wp <= '0;
      a2b_rp <= '0;
      a2b_mk <= '0;
    end else begin
      if (a2b_push_ok) a2b_wp <= a2b_wp + ONE;
      if (!a2b_replay_n)   a2b_rp <= a2b_mk;
      else if (a2b_pop_ok) a2b_rp <= a2b_rp + ONE;
      if (a2b_mark) a2b_mk <= a2b_rp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b2a_wp <= '0;
      b2a_rp <= '0;
      b2a_mk <= '0;
    end else begin
      if (!b2a_redo_n)      b2a_wp <= b2a_mk;
      else if (b2a_push_ok) b2a_wp <= b2a_wp + ONE;
      if (b2a_pop_ok) b2a_rp <= b2a_rp + ONE;
      if (b2a_mark) b2a_mk <= b2a_wp;
    end
  end

  assert_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a2b_push && a2b_count == DEPTH) |=> $stable(a2b_wr_addr));
  assert_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (b2a_pop && b2a_count == '0) |=> $stable(b2a_rd_addr));
  assert_mark_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    a2b_mark |=> a2b_mk == $past(a2b_rp));
  assert_replay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !a2b_replay_n |=> a2b_rp == $past(a2b_mk));
  assert_mark_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b2a_mark |=> b2a_mk == $past(b2a_wp));
  assert_redo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !b2a_redo_n |=> b2a_wp == $past(b2a_mk));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a2b_replay_n && !a2b_pop) |=> $stable(a2b_rd_addr));
endmodule

// File: tb/ptr_mark_ctrl_tb.sv
module ptr_mark_ctrl_tb_top;
  localparam int AW = 3;
  localparam int D = 1 << AW;
  localparam int M = 2 * D;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic a2b_push = 0, a2b_pop = 0, a2b_mark = 0, a2b_replay_n = 1;
  logic b2a_push = 0, b2a_pop = 0, b2a_mark = 0, b2a_redo_n = 1;
  logic [AW-1:0] a2b_wr_addr, a2b_rd_addr, b2a_wr_addr, b2a_rd_addr;
  logic [AW:0] a2b_count, b2a_count;

  int total = 0, bad = 0;
  int wa = 0, ra = 0, mra = 0, wb = 0, rb = 0, mwb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_mark_ctrl #(.AW(AW)) dut_i (.*);

  function automatic int cnt(int w, int r);
    return (w - r + M) % M;
  endfunction

  task automatic check(string tag);
    int ew [6];
    int aw [6];
    ew = '{wa % D, ra % D, wb % D, rb % D, cnt(wa, ra), cnt(wb, rb)};
    aw = '{int'(a2b_wr_addr), int'(a2b_rd_addr), int'(b2a_wr_addr),
           int'(b2a_rd_addr), int'(a2b_count), int'(b2a_count)};
    total++;
    if (ew != aw) begin
      bad++;
      $display("FAIL %s: got %p expected %p", tag, aw, ew);
    end
  endtask

  task automatic step(string tag, bit ap, bit ao, bit am, bit ar,
                      bit bp, bit bo, bit bm, bit br);
    int nwa, nra, nmra, nwb, nrb, nmwb;
    @(negedge clk);
    a2b_push = ap; a2b_pop = ao; a2b_mark = am; a2b_replay_n = !ar;
    b2a_push = bp; b2a_pop = bo; b2a_mark = bm; b2a_redo_n = !br;
    nwa = (ap && cnt(wa, ra) != D) ? (wa + 1) % M : wa;
    nra = ar ? mra : ((ao && cnt(wa, ra) != 0) ? (ra + 1) % M : ra);
    nmra = am ? ra : mra;
    nwb = br ? mwb : ((bp && cnt(wb, rb) != D) ? (wb + 1) % M : wb);
    nrb = (bo && cnt(wb, rb) != 0) ? (rb + 1) % M : rb;
    nmwb = bm ? wb : mwb;
    @(posedge clk);
    wa = nwa; ra = nra; mra = nmra; wb = nwb; rb = nrb; mwb = nmwb;
    #1;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    bad++; total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    #(CLK_PERIOD * 2 + 1);
    check("R1");
    rst_n = 1;
    // fill and overfill both, drain and overdrain
    for (int i = 0; i < D; i++) step("R2", 1, 0, 0, 0, 1, 0, 0, 0);
    step("R3", 1, 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < D; i++) step("R2", 0, 1, 0, 0, 0, 1, 0, 0);
    step("R3", 0, 1, 0, 0, 0, 1, 0, 0);
    // replay path
    for (int i = 0; i < 4; i++) step("R2", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R4", 0, 1, 1, 0, 0, 0, 0, 0);
    step("R4", 0, 1, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 0, 0, 0, 0);
    step("R6", 0, 1, 0, 1, 0, 0, 0, 0);
    step("R2", 0, 1, 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 1, 1, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 1, 0, 0, 0, 0);
    // overwrite path
    for (int i = 0; i < 5; i++) step("R2", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 0);
    step("R7", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 0, 1, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 1, 0, 1, 1);
    // random traffic with safe restores
    for (int i = 0; i < 4000; i++) begin
      bit ap, ao, am, ar, bp, bo, bm, br;
      int popb;
      ap = $urandom_range(0, 1); ao = $urandom_range(0, 1);
      bp = $urandom_range(0, 1); bo = $urandom_range(0, 1);
      am = ($urandom_range(0, 9) == 0);
      bm = ($urandom_range(0, 9) == 0);
      ar = ($urandom_range(0, 15) == 0) && cnt(wa, mra) <= D;
      popb = (bo && cnt(wb, rb) != 0) ? 1 : 0;
      br = ($urandom_range(0, 15) == 0) && cnt(mwb, (rb + popb) % M) <= D;
      step(ar ? "R5" : (br ? "R8" : "R2"), ap, ao, am, ar, bp, bo, bm, br);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule